// File: doc/BRIEF.md
# Digital Potentiometer Command Controller

This block is the command front end of a multi-channel digital potentiometer. A host talks to it over a four-wire serial link: chip-select, serial clock, data in and data out. Each command is a 24-bit frame. The first byte holds a 4-bit opcode in its upper nibble and an address nibble in its lower nibble. The next two bytes carry data. The block holds one 8-bit wiper position and one output-select bit per channel. Behind these registers sits a 16-word, 9-bit non-volatile store, organised as four locations per channel.

All serial inputs are brought into the system clock domain through synchronizer chains, and edges are detected there. A frame runs only when chip-select returns high after exactly 24 serial clock edges. It runs only while the device is awake and not busy. Writes to the store (program, store-from-wiper, erase) are blocked by a write-protect input. When a write is accepted, ready is held low for a programmable number of cycles. Read commands leave a 9-bit result that is shifted out on data-out during the following frames.

Top module: `dpot_cmd_ctrl`

## Requirements
- R1: Data in is sampled on each rising serial clock while chip-select is low, most significant bit first. A frame runs only when chip-select rises after exactly 24 rising clocks. Frames with any other bit count change nothing.
- R2: Opcode 0100 loads D7..D0 into the wiper of the channel named by A1..A0. A3..A2 have no effect, and the channel's select bit is unchanged.
- R3: Opcode 1100 captures {select, wiper} of channel A1..A0, and opcode 1010 captures store word {A1A0,A3A2}. The captured 9-bit value is driven on data-out during every later frame, MSB first over 24 clocks with zeros above bit 8, until the next read command replaces it. It is 0 after reset.
- R4: Opcode 0010 writes D8..D0 into store word {A1A0,A3A2}. Ready then stays low for exactly BUSY_CYC clock cycles.
- R5: Opcode 1011 copies store word {A1A0,A3A2} into channel A1..A0, with bit 8 going to the select bit and bits 7..0 to the wiper. Opcode 0011 writes {select, wiper} of that channel into that word and starts the busy period.
- R6: Opcode 0111 raises the channel's wiper by one and stops at 255. Opcode 1111 lowers it by one and stops at 0.
- R7: Opcode 1101 sets store word {A1A0,A3A2} to 0x1FF and starts the busy period.
- R8: While write-protect is high, opcodes 0010, 0011 and 1101 change no store word, and ready stays high.
- R9: A frame that completes while ready is low has no effect.
- R10: After hardware reset the device is asleep. Opcode 1000 puts it to sleep and opcode 0001 wakes it. While asleep, every opcode other than 0001 is ignored.
- R11: Opcode 1001 reloads every channel's select bit and wiper from that channel's location 0. The device stays awake.
- R12: Hardware reset leaves every wiper at 255, every select bit at 1, every store word at 0x1FF, ready high and data-out low.
- R13: Opcodes 0000, 0101, 0110 and 1110 change no wiper, select bit, store word or read result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial command data from the host |
| miso | output | 1 | Serial read data to the host |
| wp | input | 1 | Write protect for the non-volatile store |
| rdy | output | 1 | High when the block can take a command |
| tap_o | output | 32 | Wiper positions, channel c at bits 8c+7..8c |
| sel_o | output | 4 | Output-select bit per channel |

## Verification
The bench builds the block with BUSY_CYC = 300 and SYNC_STG = 2. With a short busy period, each store write can be run to completion and its ready-low window compared edge for edge against a cycle-counting model. The busy period is still longer than a whole serial frame, so a second frame can be sent and completed inside the window. The fixed two-stage synchronizer lets the model predict the exact cycle in which a command takes effect and compare wipers, select bits and ready on every clock.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int CH_W    = 2;
  localparam int LOC_W   = 2;
  localparam int NCH     = 1 << CH_W;
  localparam int NLOC    = 1 << LOC_W;
  localparam int TAP_W   = 8;
  localparam int WORD_W  = TAP_W + 1;
  localparam int AW      = CH_W + LOC_W;
  localparam int NWORDS  = 1 << AW;
  localparam int FRAME_W = 24;
  localparam int CMD_W   = 8;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  typedef enum logic [3:0] {
    OP_NOP   = 4'b0000,
    OP_WAKE  = 4'b0001,
    OP_PROG  = 4'b0010,
    OP_STORE = 4'b0011,
    OP_WRTAP = 4'b0100,
    OP_INC   = 4'b0111,
    OP_SLEEP = 4'b1000,
    OP_SRST  = 4'b1001,
    OP_RDNV  = 4'b1010,
    OP_LOAD  = 4'b1011,
    OP_RDTAP = 4'b1100,
    OP_ERASE = 4'b1101,
    OP_DEC   = 4'b1111
  } op_e;
endpackage

// File: rtl/dpc_sync.sv
module dpc_sync #(
  parameter int W = 1,
  parameter int STG = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STG-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STG{RST_VAL}};
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STG; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STG-1];
endmodule

// File: rtl/dpc_spi_rx.sv
module dpc_spi_rx
  import dpc_pkg::*;
#(
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              wp,
  input  logic [WORD_W-1:0] resp_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [WORD_W-1:0] dat_o,
  output logic              exec_o,
  output logic              wp_o,
  output logic              miso_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic cs_s, sclk_s, mosi_s;
  logic cs_prev_q, sclk_prev_q;
  logic cs_fall, cs_rise, sclk_rise;
  logic [FRAME_W-1:0] sr_q, sr_d, out_q, out_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  dpc_sync #(.W(4), .STG(SYNC_STG), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sclk, mosi, wp}),
    .q({cs_s, sclk_s, mosi_s, wp_o})
  );

  assign cs_fall   = !cs_s && cs_prev_q;
  assign cs_rise   = cs_s && !cs_prev_q;
  assign sclk_rise = sclk_s && !sclk_prev_q && !cs_s;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    out_d = out_q;
    if (cs_fall) begin
      cnt_d = '0;
      out_d = {{(FRAME_W-WORD_W){1'b0}}, resp_i};
    end else if (sclk_rise) begin
      sr_d  = {sr_q[FRAME_W-2:0], mosi_s};
      out_d = {out_q[FRAME_W-2:0], 1'b0};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      sr_q        <= '0;
      cnt_q       <= '0;
      out_q       <= '0;
    end else begin
      cs_prev_q   <= cs_s;
      sclk_prev_q <= sclk_s;
      if (cs_fall || sclk_rise) begin
        sr_q  <= sr_d;
        cnt_q <= cnt_d;
        out_q <= out_d;
      end
    end
  end

  assign exec_o = cs_rise && (cnt_q == CNT_FULL);
  assign cmd_o  = sr_q[FRAME_W-1 -: CMD_W];
  assign dat_o  = sr_q[WORD_W-1:0];
  assign miso_o = out_q[FRAME_W-1];

  assert_exec_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |=> !exec_o) else $error("frame strobe longer than one cycle");
endmodule

// File: rtl/dpc_nvmem.sv
module dpc_nvmem
  import dpc_pkg::*;
#(
  parameter int BUSY_CYC = 2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [WORD_W-1:0]        wdata_i,
  output logic [NWORDS*WORD_W-1:0] mem_o,
  output logic                     rdy_o
);
  localparam int BC_W = $clog2(BUSY_CYC + 1);

  logic [NWORDS-1:0][WORD_W-1:0] mem_q;
  logic [NWORDS-1:0]             wen;
  logic [BC_W-1:0]               bcnt_q, bcnt_d;

  for (genvar w = 0; w < NWORDS; w++) begin : g_wen
    assign wen[w] = we_i && (waddr_i == AW'(w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '1;
    end else begin
      for (int w = 0; w < NWORDS; w++) begin
        if (wen[w]) mem_q[w] <= wdata_i;
      end
    end
  end

  always_comb begin
    bcnt_d = bcnt_q;
    if (we_i)             bcnt_d = BC_W'(BUSY_CYC);
    else if (bcnt_q != 0) bcnt_d = bcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt_q <= '0;
    else        bcnt_q <= bcnt_d;
  end

  assign rdy_o = (bcnt_q == '0);
  assign mem_o = mem_q;

  assert_we_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> rdy_o) else $error("store written while busy");
  assert_busy_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_o) |-> $past(we_i)) else $error("busy without a write");
endmodule

// File: rtl/dpc_core.sv
module dpc_core
  import dpc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     exec_i,
  input  logic [CMD_W-1:0]         cmd_i,
  input  logic [WORD_W-1:0]        dat_i,
  input  logic                     wp_i,
  input  logic                     nvm_rdy_i,
  input  logic [NWORDS*WORD_W-1:0] nvm_mem_i,
  output logic                     nvm_we_o,
  output logic [AW-1:0]            nvm_waddr_o,
  output logic [WORD_W-1:0]        nvm_wdata_o,
  output logic [NCH*TAP_W-1:0]     tap_o,
  output logic [NCH-1:0]           sel_o,
  output logic [WORD_W-1:0]        resp_o
);
  op_e                           op;
  logic [CH_W-1:0]               ch;
  logic [LOC_W-1:0]              loc;
  logic [AW-1:0]                 idx;
  logic [NWORDS-1:0][WORD_W-1:0] mem_w;
  logic                          go, act;

  logic [NCH-1:0][TAP_W-1:0] tap_q, tap_d;
  logic [NCH-1:0]            sel_q, sel_d;
  logic [WORD_W-1:0]         resp_q, resp_d;
  logic                      asleep_q, asleep_d;

  assign op    = op_e'(cmd_i[CMD_W-1 -: 4]);
  assign loc   = cmd_i[AW-1 -: LOC_W];
  assign ch    = cmd_i[CH_W-1:0];
  assign idx   = {ch, loc};
  assign mem_w = nvm_mem_i;
  assign go    = exec_i && nvm_rdy_i;
  assign act   = go && !asleep_q;

  always_comb begin
    tap_d       = tap_q;
    sel_d       = sel_q;
    resp_d      = resp_q;
    asleep_d    = asleep_q;
    nvm_we_o    = 1'b0;
    nvm_waddr_o = idx;
    nvm_wdata_o = '0;
    if (go && asleep_q && op == OP_WAKE) asleep_d = 1'b0;
    if (act) begin
      case (op)
        OP_RDTAP: resp_d = {sel_q[ch], tap_q[ch]};
        OP_WRTAP: tap_d[ch] = dat_i[TAP_W-1:0];
        OP_RDNV:  resp_d = mem_w[idx];
        OP_PROG: if (!wp_i) begin
          nvm_we_o    = 1'b1;
          nvm_wdata_o = dat_i;
        end
        OP_LOAD:  {sel_d[ch], tap_d[ch]} = mem_w[idx];
        OP_STORE: if (!wp_i) begin
          nvm_we_o    = 1'b1;
          nvm_wdata_o = {sel_q[ch], tap_q[ch]};
        end
        OP_INC:   if (tap_q[ch] != '1) tap_d[ch] = tap_q[ch] + 1'b1;
        OP_DEC:   if (tap_q[ch] != '0) tap_d[ch] = tap_q[ch] - 1'b1;
        OP_SLEEP: asleep_d = 1'b1;
        OP_ERASE: if (!wp_i) begin
          nvm_we_o    = 1'b1;
          nvm_wdata_o = '1;
        end
        OP_SRST: begin
          for (int c = 0; c < NCH; c++) begin
            {sel_d[c], tap_d[c]} = mem_w[AW'(c * NLOC)];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q    <= '1;
      sel_q    <= '1;
      resp_q   <= '0;
      asleep_q <= 1'b1;
    end else if (go) begin
      tap_q    <= tap_d;
      sel_q    <= sel_d;
      resp_q   <= resp_d;
      asleep_q <= asleep_d;
    end
  end

  assign tap_o  = tap_q;
  assign sel_o  = sel_q;
  assign resp_o = resp_q;

  assert_sleep_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_q |-> !nvm_we_o) else $error("store written while asleep");

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      asleep_q |=> ($stable(tap_q[i]) && $stable(sel_q[i])))
      else $error("channel moved while asleep");
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act && (op == OP_INC || op == OP_DEC)) |=>
        (tap_q[i] == $past(tap_q[i])) ||
        ($past(tap_q[i]) != '1 && tap_q[i] == $past(tap_q[i]) + 1'b1) ||
        ($past(tap_q[i]) != '0 && tap_q[i] == $past(tap_q[i]) - 1'b1))
      else $error("wiper step wrapped or jumped");
  end
endmodule

// File: rtl/dpot_cmd_ctrl.sv
module dpot_cmd_ctrl
  import dpc_pkg::*;
#(
  parameter int BUSY_CYC = 2000,
  parameter int SYNC_STG = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 mosi,
  output logic                 miso,
  input  logic                 wp,
  output logic                 rdy,
  output logic [NCH*TAP_W-1:0] tap_o,
  output logic [NCH-1:0]       sel_o
);
  logic                     rst_n_s;
  logic [CMD_W-1:0]         cmd;
  logic [WORD_W-1:0]        dat, resp, wdata;
  logic                     exec, wp_s, we;
  logic [AW-1:0]            waddr;
  logic [NWORDS*WORD_W-1:0] mem;

  dpc_sync #(.W(1), .STG(2), .RST_VAL(1'b0)) u_rsync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  dpc_spi_rx #(.SYNC_STG(SYNC_STG)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .wp(wp), .resp_i(resp), .cmd_o(cmd), .dat_o(dat), .exec_o(exec),
    .wp_o(wp_s), .miso_o(miso)
  );

  dpc_core u_core (
    .clk(clk), .rst_n(rst_n_s), .exec_i(exec), .cmd_i(cmd), .dat_i(dat),
    .wp_i(wp_s), .nvm_rdy_i(rdy), .nvm_mem_i(mem), .nvm_we_o(we),
    .nvm_waddr_o(waddr), .nvm_wdata_o(wdata), .tap_o(tap_o), .sel_o(sel_o),
    .resp_o(resp)
  );

  dpc_nvmem #(.BUSY_CYC(BUSY_CYC)) u_nvm (
    .clk(clk), .rst_n(rst_n_s), .we_i(we), .waddr_i(waddr),
    .wdata_i(wdata), .mem_o(mem), .rdy_o(rdy)
  );

  assert_wp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(wp_s) |-> !$fell(rdy)) else $error("busy started under write protect");
endmodule

// File: tb/sim_dpot_cmd_ctrl.sv
module sim_dpot_cmd_ctrl;
  localparam int BUSY = 300;
  localparam int STG  = 2;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, mosi, wp;
  logic miso, rdy;
  logic [31:0] tap_o;
  logic [3:0]  sel_o;

  always #2 clk = ~clk;

  dpot_cmd_ctrl #(.BUSY_CYC(BUSY), .SYNC_STG(STG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .wp(wp), .rdy(rdy), .tap_o(tap_o), .sel_o(sel_o)
  );

  int n_tests = 0, n_fail = 0;
  longint cyc = 0, bs = 0, be = 0, blank_until = 0;
  bit mon_en = 0, done = 0;
  string cur_req = "R12";

  int m_tap[4], m_sel[4], m_mem[16], m_resp, m_asleep;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && !done) begin
      chk(cur_req, int'(rdy), (cyc >= bs && cyc < be) ? 0 : 1);
      if (cyc >= blank_until) begin
        for (int c = 0; c < 4; c++) begin
          chk(cur_req, int'(tap_o[c*8 +: 8]), m_tap[c]);
          chk(cur_req, int'(sel_o[c]), m_sel[c]);
        end
      end
    end
  end

  task automatic apply(input logic [23:0] w, input longint k);
    longint e = k + STG + 1;
    int op  = int'(w[23:20]);
    int loc = int'(w[19:18]);
    int ch  = int'(w[17:16]);
    int idx = ch * 4 + loc;
    blank_until = e;
    if (e >= bs && e < be) return;
    if (m_asleep != 0) begin
      if (op == 1) m_asleep = 0;
      return;
    end
    case (op)
      12: m_resp = m_sel[ch] * 256 + m_tap[ch];
      4:  m_tap[ch] = int'(w[7:0]);
      10: m_resp = m_mem[idx];
      2:  if (!wp) begin m_mem[idx] = int'(w[8:0]); bs = e; be = e + BUSY; end
      11: begin m_tap[ch] = m_mem[idx] % 256; m_sel[ch] = m_mem[idx] / 256; end
      3:  if (!wp) begin m_mem[idx] = m_sel[ch] * 256 + m_tap[ch]; bs = e; be = e + BUSY; end
      7:  if (m_tap[ch] < 255) m_tap[ch]++;
      15: if (m_tap[ch] > 0) m_tap[ch]--;
      8:  m_asleep = 1;
      13: if (!wp) begin m_mem[idx] = 511; bs = e; be = e + BUSY; end
      9:  for (int c = 0; c < 4; c++) begin
            m_tap[c] = m_mem[c*4] % 256;
            m_sel[c] = m_mem[c*4] / 256;
          end
      default: ;
    endcase
  endtask

  task automatic frame(input logic [23:0] w, input int nbits);
    logic [23:0] got = '0, mask = '0;
    logic [23:0] exp = {15'b0, 9'(m_resp)};
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? w[23-i] : 1'b0;
      repeat (4) @(negedge clk);
      if (i < 24) begin
        got[23-i]  = miso;
        mask[23-i] = 1'b1;
      end
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    if (nbits == 24) apply(w, cyc);
    chk({cur_req, " R3 data-out"}, int'(got & mask), int'(exp & mask));
    repeat (8) @(negedge clk);
  endtask

  task automatic cmd(input logic [3:0] op, input logic [1:0] ch,
                     input logic [1:0] loc, input logic [8:0] dat);
    frame({op, loc, ch, 7'b0, dat}, 24);
  endtask

  task automatic wait_idle();
    while (cyc < be + 2) @(negedge clk);
  endtask

  task automatic read_nv(input logic [1:0] ch, input logic [1:0] loc, input int exp_val);
    cmd(4'b1010, ch, loc, 9'h0);
    chk({cur_req, " captured word"}, m_resp, exp_val);
    cmd(4'b0000, 2'd0, 2'd0, 9'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; wp = 1'b0;
    for (int c = 0; c < 4; c++) begin m_tap[c] = 255; m_sel[c] = 1; end
    for (int w = 0; w < 16; w++) m_mem[w] = 511;
    m_resp = 0; m_asleep = 1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R12: reset state
    chk("R12 tap0", int'(tap_o[7:0]), 255);
    chk("R12 sel", int'(sel_o), 15);
    chk("R12 rdy", int'(rdy), 1);
    chk("R12 miso", int'(miso), 0);
    mon_en = 1;

    // R10: asleep after reset, commands ignored
    cur_req = "R10";
    cmd(4'b0100, 2'd0, 2'd0, 9'h012);
    cmd(4'b0111, 2'd1, 2'd0, 9'h0);
    cmd(4'b1100, 2'd0, 2'd0, 9'h0);
    chk("R10 ignored while asleep", int'(tap_o[7:0]), 255);
    cmd(4'b0001, 2'd0, 2'd0, 9'h0);

    // R2: write wiper, A3..A2 and D8 ignored
    cur_req = "R2";
    cmd(4'b0100, 2'd1, 2'd3, 9'h15A);
    chk("R2 write ch1", int'(tap_o[15:8]), 8'h5A);
    chk("R2 sel kept", int'(sel_o[1]), 1);

    // R3: read wiper, result persists over frames
    cur_req = "R3";
    cmd(4'b1100, 2'd1, 2'd0, 9'h0);
    cmd(4'b0000, 2'd0, 2'd0, 9'h0);
    cmd(4'b0000, 2'd0, 2'd0, 9'h0);
    chk("R3 persisted result", m_resp, 9'h15A);

    // R4: program + busy window; R9: frame inside busy is dropped
    cur_req = "R4";
    cmd(4'b0010, 2'd2, 2'd1, 9'h0A5);
    cur_req = "R9";
    cmd(4'b0100, 2'd0, 2'd0, 9'h033);
    chk("R9 busy frame dropped", int'(tap_o[7:0]), 255);
    wait_idle();
    cur_req = "R4";
    read_nv(2'd2, 2'd1, 9'h0A5);

    // R5: load and store
    cur_req = "R5";
    cmd(4'b1011, 2'd2, 2'd1, 9'h0);
    chk("R5 load tap", int'(tap_o[23:16]), 8'hA5);
    chk("R5 load sel", int'(sel_o[2]), 0);
    cmd(4'b0011, 2'd1, 2'd2, 9'h0);
    wait_idle();
    read_nv(2'd1, 2'd2, 9'h15A);

    // R6: saturation both ways
    cur_req = "R6";
    cmd(4'b0100, 2'd0, 2'd0, 9'h0FE);
    cmd(4'b0111, 2'd0, 2'd0, 9'h0);
    cmd(4'b0111, 2'd0, 2'd0, 9'h0);
    chk("R6 top stop", int'(tap_o[7:0]), 255);
    cmd(4'b0100, 2'd3, 2'd0, 9'h001);
    cmd(4'b1111, 2'd3, 2'd0, 9'h0);
    cmd(4'b1111, 2'd3, 2'd0, 9'h0);
    chk("R6 bottom stop", int'(tap_o[31:24]), 0);
    cmd(4'b0111, 2'd3, 2'd0, 9'h0);
    chk("R6 step up", int'(tap_o[31:24]), 1);

    // R7: erase
    cur_req = "R7";
    cmd(4'b1101, 2'd2, 2'd1, 9'h0);
    wait_idle();
    read_nv(2'd2, 2'd1, 9'h1FF);

    // R8: write protect
    cur_req = "R8";
    @(negedge clk) wp = 1'b1;
    repeat (8) @(negedge clk);
    cmd(4'b0010, 2'd1, 2'd2, 9'h000);
    cmd(4'b1101, 2'd1, 2'd2, 9'h0);
    cmd(4'b0011, 2'd1, 2'd2, 9'h0);
    chk("R8 rdy stays high", int'(rdy), 1);
    @(negedge clk) wp = 1'b0;
    repeat (8) @(negedge clk);
    read_nv(2'd1, 2'd2, 9'h15A);

    // R1: wrong-length frames discarded
    cur_req = "R1";
    frame({4'b0100, 2'd0, 2'd0, 7'b0, 9'h011}, 16);
    frame({4'b0100, 2'd0, 2'd0, 7'b0, 9'h022}, 25);
    chk("R1 odd lengths dropped", int'(tap_o[7:0]), 255);
    cmd(4'b0100, 2'd0, 2'd0, 9'h081);
    chk("R1 msb first", int'(tap_o[7:0]), 8'h81);

    // R13: unassigned opcodes
    cur_req = "R13";
    cmd(4'b0101, 2'd0, 2'd0, 9'h000);
    cmd(4'b0110, 2'd0, 2'd0, 9'h000);
    cmd(4'b1110, 2'd0, 2'd0, 9'h000);
    cmd(4'b0000, 2'd0, 2'd0, 9'h000);
    chk("R13 no effect", int'(tap_o[7:0]), 8'h81);

    // R11: software reset reloads location 0
    cur_req = "R11";
    cmd(4'b0010, 2'd0, 2'd0, 9'h123);
    wait_idle();
    cmd(4'b0100, 2'd0, 2'd0, 9'h044);
    cmd(4'b1001, 2'd0, 2'd0, 9'h0);
    chk("R11 ch0 tap", int'(tap_o[7:0]), 8'h23);
    chk("R11 ch0 sel", int'(sel_o[0]), 1);
    chk("R11 ch3 tap", int'(tap_o[31:24]), 255);
    cmd(4'b0100, 2'd1, 2'd0, 9'h077);
    chk("R11 stays awake", int'(tap_o[15:8]), 8'h77);

    // R10: sleep then wake
    cur_req = "R10";
    cmd(4'b1000, 2'd0, 2'd0, 9'h0);
    cmd(4'b0111, 2'd1, 2'd0, 9'h0);
    cmd(4'b0010, 2'd0, 2'd1, 9'h000);
    chk("R10 asleep no step", int'(tap_o[15:8]), 8'h77);
    chk("R10 asleep no busy", int'(rdy), 1);
    cmd(4'b0001, 2'd0, 2'd0, 9'h0);
    cmd(4'b0111, 2'd1, 2'd0, 9'h0);
    chk("R10 awake step", int'(tap_o[15:8]), 8'h78);
    read_nv(2'd0, 2'd1, 9'h1FF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule